// File: doc/BRIEF.md
# Multiplexed Bus Byte-Select Write Controller

This block takes a single-byte write request and runs it as one write cycle on a 16-bit external bus. The bus multiplexes address and data on the same lines. The target is a word-wide memory that can select single bytes. The request carries an 8-bit value and a 21-bit byte pointer. Bit 0 of the pointer picks the byte lane. The remaining bits form the word address, which goes out on the shared AD lines during an address phase marked by a latch-enable pulse. After that phase, the byte is placed on both halves of the bus.

A write is performed by pulsing the high-side write strobe. The low-side strobe and the output enable stay inactive throughout. Byte selection reaches the memory in two forms at once, so either memory type can be attached directly:
- a plain byte-address bit, for Flash-style parts;
- a pair of active-low upper/lower selects, for SRAM-style parts.

A static byte/word mode level is passed straight through to a pin. The strobe length is taken from a small configuration input when the request is accepted. Upper address lines are driven only when the wide-address option is on.

Top module: `mbus_bytewr`

## Requirements
- R1: `req_ready` is high only while no cycle is in progress. A request is accepted on a rising clock edge where `req_valid` and `req_ready` are both high. While a cycle is in progress, `req_valid` has no effect.
- R2: In the clock after acceptance, `ale` is high for exactly one clock, `ad_oe` is high and `ad_out` equals pointer bits [16:1].
- R3: In the following clock (data phase), and in every clock after it until the cycle ends, `ad_out` equals the request byte repeated in both the upper and lower 8 bits.
- R4: Directly after the data phase, `wrh_n` is low for N consecutive clocks. N is the value of `cfg_strobe_len` sampled at acceptance, with 0 treated as 1. At all other times `wrh_n` is high.
- R5: `wrl_n` and `oe_n` are high at all times.
- R6: During a cycle, pointer bit 0 = 0 drives `lb_n` low and `ub_n` high, and bit 0 = 1 drives `ub_n` low and `lb_n` high. Outside a cycle, both are high.
- R7: During a cycle, `ba0` equals pointer bit 0. Outside a cycle, `ba0` is 0.
- R8: During a cycle, `a_hi` equals pointer bits [20:17] if `cfg_addr20` was high at acceptance, and 0 otherwise. Outside a cycle, `a_hi` is 0.
- R9: After the last strobe clock there is one hold clock. In it, `wrh_n` is high, the data is unchanged and `done` is high. `done` is never high in any other clock. The block is ready again in the next clock.
- R10: Outside a cycle, `ad_oe` is low and `ad_out` is 0.
- R11: `byte_mode_out` always equals `cfg_byte_mode_in`, independently of the write sequence.
- R12: While `rst_n` is low, all outputs hold their idle values: ready high, `ale` low, all strobes high, selects high, `ad_oe` low and buses zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_ptr | input | 21 | Byte pointer; bit 0 picks the lane |
| req_data | input | 8 | Byte to write |
| cfg_strobe_len | input | 2 | Write strobe length in clocks (0 means 1) |
| cfg_addr20 | input | 1 | Drive upper address lines |
| cfg_byte_mode_in | input | 1 | Static byte/word select for Flash parts |
| done | output | 1 | One-clock pulse in the hold clock |
| ad_out | output | 16 | Multiplexed address/data value |
| ad_oe | output | 1 | Output enable for the AD drivers |
| a_hi | output | 4 | Upper word-address lines |
| ale | output | 1 | Address latch enable, active high |
| oe_n | output | 1 | Memory output enable, active low |
| wrh_n | output | 1 | High-side write strobe, active low |
| wrl_n | output | 1 | Low-side write strobe, active low (unused, held high) |
| ba0 | output | 1 | Byte address for Flash parts |
| ub_n | output | 1 | Upper byte select, active low |
| lb_n | output | 1 | Lower byte select, active low |
| byte_mode_out | output | 1 | Pin copy of `cfg_byte_mode_in` |

## Verification
A wrong sequencer state shows at the ports in the same clock, because every bus output is decoded straight from that state. A skipped or repeated phase moves the `ale` pulse, the data pattern or the strobe edge by one clock. A wrong strobe count moves `done` and the return of `req_ready`. A corrupted latched pointer or byte shows up in the first clock of the cycle, on `ad_out`, the selects or `a_hi`, and again in the data phase. The bench therefore compares every output in every clock against a queue of expected phases, so any such error is reported within one clock of its effect.

// File: rtl/mbus_bytewr.sv
module mbus_bytewr #(
  parameter int PTR_W  = 21,
  parameter int DATA_W = 8,
  parameter int LEN_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PTR_W-1:0]  req_ptr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [LEN_W-1:0]  cfg_strobe_len,
  input  logic              cfg_addr20,
  input  logic              cfg_byte_mode_in,
  output logic              done,
  output logic [2*DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [PTR_W-2*DATA_W-2:0] a_hi,
  output logic              ale,
  output logic              oe_n,
  output logic              wrh_n,
  output logic              wrl_n,
  output logic              ba0,
  output logic              ub_n,
  output logic              lb_n,
  output logic              byte_mode_out
);
  localparam int AD_W = 2 * DATA_W;
  localparam int HI_W = PTR_W - AD_W - 1;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_DATA, S_STRB, S_HOLD} st_t;

  st_t              st;
  logic [PTR_W-1:0] ptr_q;
  logic [DATA_W-1:0] dat_q;
  logic [LEN_W-1:0] len_q, cnt;
  logic             a20_q;
  logic             busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      ptr_q <= '0;
      dat_q <= '0;
      len_q <= '0;
      cnt   <= '0;
      a20_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          ptr_q <= req_ptr;
          dat_q <= req_data;
          len_q <= (cfg_strobe_len == '0) ? LEN_W'(1) : cfg_strobe_len;
          a20_q <= cfg_addr20;
          st    <= S_ADDR;
        end
        S_ADDR: st <= S_DATA;
        S_DATA: begin
          cnt <= LEN_W'(1);
          st  <= S_STRB;
        end
        S_STRB: begin
          if (cnt == len_q) st <= S_HOLD;
          else cnt <= cnt + LEN_W'(1);
        end
        S_HOLD: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy          = (st != S_IDLE);
  assign req_ready     = !busy;
  assign ale           = (st == S_ADDR);
  assign wrh_n         = (st != S_STRB);
  assign wrl_n         = 1'b1;
  assign oe_n          = 1'b1;
  assign done          = (st == S_HOLD);
  assign ad_oe         = busy;
  assign ad_out        = !busy ? '0 :
                         ale   ? ptr_q[AD_W:1] : {dat_q, dat_q};
  assign a_hi          = (busy && a20_q) ? ptr_q[PTR_W-1:AD_W+1] : HI_W'(0);
  assign ba0           = busy && ptr_q[0];
  assign ub_n          = !(busy && ptr_q[0]);
  assign lb_n          = !(busy && !ptr_q[0]);
  assign byte_mode_out = cfg_byte_mode_in;
endmodule

module mbus_bytewr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        done,
  input logic [15:0] ad_out,
  input logic        ad_oe,
  input logic        ale,
  input logic        oe_n,
  input logic        wrh_n,
  input logic        wrl_n,
  input logic        ub_n,
  input logic        lb_n
);
  AST_ACCEPT_ALE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> ale) else $error("accept");  // R1
  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale) else $error("ale");  // R2
  AST_STRB_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wrh_n |=> ad_out == $past(ad_out)) else $error("data");  // R3
  AST_WRL_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    wrl_n && oe_n) else $error("wrl/oe");  // R5
  AST_SEL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    ub_n || lb_n) else $error("sel");  // R6
  AST_DONE_AFTER_STRB: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> wrh_n && $past(!wrh_n)) else $error("done");  // R9
  AST_DONE_THEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready) else $error("ready");  // R9
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !ad_oe && ad_out == 16'h0) else $error("idle");  // R10
endmodule

bind mbus_bytewr mbus_bytewr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .done(done), .ad_out(ad_out), .ad_oe(ad_oe), .ale(ale), .oe_n(oe_n),
  .wrh_n(wrh_n), .wrl_n(wrl_n), .ub_n(ub_n), .lb_n(lb_n)
);

// File: tb/mbus_bytewr_bench.sv
module mbus_bytewr_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [20:0] req_ptr = '0;
  logic [7:0] req_data = '0;
  logic [1:0] cfg_strobe_len = 2'd1;
  logic cfg_addr20 = 1'b0;
  logic cfg_byte_mode_in = 1'b0;
  logic req_ready, done, ad_oe, ale, oe_n, wrh_n, wrl_n, ba0, ub_n, lb_n, byte_mode_out;
  logic [15:0] ad_out;
  logic [3:0] a_hi;

  always #10 clk = ~clk;

  mbus_bytewr u_mbus_bytewr (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_ptr(req_ptr), .req_data(req_data), .cfg_strobe_len(cfg_strobe_len),
    .cfg_addr20(cfg_addr20), .cfg_byte_mode_in(cfg_byte_mode_in), .done(done),
    .ad_out(ad_out), .ad_oe(ad_oe), .a_hi(a_hi), .ale(ale), .oe_n(oe_n),
    .wrh_n(wrh_n), .wrl_n(wrl_n), .ba0(ba0), .ub_n(ub_n), .lb_n(lb_n),
    .byte_mode_out(byte_mode_out)
  );

  // phase codes: 1 address, 2 data, 3 strobe, 4 hold
  int q[$];
  logic [20:0] m_ptr;
  logic [7:0]  m_dat;
  logic        m_a20;
  int vectors = 0;
  int miscompares = 0;
  int accepts = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
    end else if (q.size() > 0) begin
      void'(q.pop_front());
    end else if (req_valid) begin
      int n;
      m_ptr = req_ptr; m_dat = req_data; m_a20 = cfg_addr20;
      n = (cfg_strobe_len == 0) ? 1 : int'(cfg_strobe_len);
      q.push_back(1); q.push_back(2);
      for (int i = 0; i < n; i++) q.push_back(3);
      q.push_back(4);
      accepts++;
    end
  end

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    int ph;
    logic [15:0] e_ad;
    ph = (q.size() > 0) ? q[0] : 0;
    if (!rst_n) begin
      cmp("R12 ready", req_ready, 1);
      cmp("R12 ad_oe", ad_oe, 0);
      cmp("R12 strobes", {wrh_n, wrl_n, oe_n, ale}, 4'b1110);
      cmp("R12 sel", {ub_n, lb_n, ba0, a_hi, ad_out}, {3'b110, 20'h0});
    end else begin
      e_ad = (ph == 0) ? 16'h0 : (ph == 1) ? m_ptr[16:1] : {m_dat, m_dat};
      cmp("R1 ready", req_ready, ph == 0);
      cmp("R2 ale", ale, ph == 1);
      cmp(ph == 1 ? "R2 ad_out" : (ph == 0 ? "R10 ad_out" : "R3 ad_out"), ad_out, e_ad);
      cmp(ph == 0 ? "R10 ad_oe" : "R2 ad_oe", ad_oe, ph != 0);
      cmp("R4 wrh_n", wrh_n, ph != 3);
      cmp("R5 wrl_n/oe_n", {wrl_n, oe_n}, 2'b11);
      cmp("R6 ub_n", ub_n, !(ph != 0 && m_ptr[0]));
      cmp("R6 lb_n", lb_n, !(ph != 0 && !m_ptr[0]));
      cmp("R7 ba0", ba0, ph != 0 && m_ptr[0]);
      cmp("R8 a_hi", a_hi, (ph != 0 && m_a20) ? m_ptr[20:17] : 4'h0);
      cmp("R9 done", done, ph == 4);
    end
    cmp("R11 byte_mode_out", byte_mode_out, cfg_byte_mode_in);
  end

  task automatic drive(input logic v, input logic [20:0] p, input logic [7:0] d,
                       input logic [1:0] l, input logic a20);
    @(negedge clk);
    req_valid = v; req_ptr = p; req_data = d; cfg_strobe_len = l; cfg_addr20 = a20;
    cfg_byte_mode_in = $urandom_range(0, 1);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #100000;
    miscompares++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) drive(1'b1, 21'h1ABCDE, 8'h5A, 2'd2, 1'b1); // valid under reset ignored (R12)
    @(negedge clk); rst_n = 1'b1;
    // R4 lengths 0..3, R6/R7 even and odd pointers, R8 both widths
    drive(1'b1, 21'h1F0002, 8'hA5, 2'd0, 1'b1);
    drive(1'b1, 21'h0E1235, 8'h3C, 2'd3, 1'b1); // held valid while busy (R1)
    repeat (8) drive(1'b1, 21'h0E1235, 8'h3C, 2'd3, 1'b1);
    drive(1'b0, 21'h0, 8'h0, 2'd1, 1'b0);
    repeat (3) drive(1'b0, 21'h0, 8'h0, 2'd1, 1'b0);
    drive(1'b1, 21'h1FFFFF, 8'hFF, 2'd2, 1'b0);
    drive(1'b1, 21'h000000, 8'h00, 2'd1, 1'b1);
    for (int i = 0; i < 60; i++)
      drive($urandom_range(0, 3) != 0, 21'($urandom), 8'($urandom),
            2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
    repeat (10) drive(1'b0, 21'h0, 8'h0, 2'd1, 1'b0);
    if (accepts < 5) begin
      miscompares++;
      $display("FAIL R1 too few accepts: actual %0d expected >=5", accepts);
    end
    finish_run();
  end
endmodule